// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two 18-bit ports, A and B, with one data path for each direction. Each path has four controls of its own. The first is an active-low drive enable. The second is a level latch enable. The third is a capture clock, sampled by the block's system clock so that its rising edges can be detected. The fourth is an active-low capture enable. Together these controls pick one of three behaviours for the path. With the latch enable high, the path is transparent. With the latch enable low, it either holds its stored value or captures a new value on an enabled rising edge of the capture clock.

The two paths share no control. A-to-B takes `a_in` and produces `b_out`. B-to-A takes `b_in` and produces `a_out`. Tri-state drive is modelled as a data output plus a drive-enable flag for each port. The surrounding pad logic uses the flag to decide whether the port is driven or left floating. A single storage register per path acts as both latch and edge register. While the path is transparent, the register follows the input, so a later fall of the latch enable leaves the last passed value in place.

Top module: `bus_xcvr`

## Requirements
- R1: `b_drv` is high exactly when `ab_oe_n` is low, and `a_drv` is high exactly when `ba_oe_n` is low, whatever the other controls are doing.
- R2: While `ab_le` is high, `b_out` equals `a_in` in the same cycle, with no register delay.
- R3: When `ab_le` and `ab_ck_en_n` are low, and `ab_ck` is sampled high at a system clock edge after being sampled low at the previous edge, `a_in` is stored at that edge. `b_out` shows the stored value from the next cycle.
- R4: While `ab_le` is low and no enabled rising capture edge occurs, `b_out` keeps its value. This holds whether `ab_ck` sits low or high, including when `ab_ck` was already high as the latch enable fell.
- R5: While `ab_ck_en_n` is high, rising edges of `ab_ck` with `ab_le` low do not change the stored value.
- R6: After `ab_le` falls, `b_out` equals the `a_in` value sampled at the last system clock edge at which `ab_le` was high.
- R7: The B-to-A path follows R2 to R6 with `ba_oe_n`, `ba_le`, `ba_ck`, `ba_ck_en_n`, `b_in` and `a_out`.
- R8: Synchronous reset `rst` clears both stored values to zero. With a latch enable low, the matching output reads zero in the cycle after reset. A capture clock held high through reset produces no capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all controls |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data arriving on port A |
| a_out | output | 18 | Data sent toward port A (B-to-A path) |
| a_drv | output | 1 | Port A drive enable |
| b_in | input | 18 | Data arriving on port B |
| b_out | output | 18 | Data sent toward port B (A-to-B path) |
| b_drv | output | 1 | Port B drive enable |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_le | input | 1 | A-to-B latch enable, high means transparent |
| ab_ck | input | 1 | A-to-B capture clock |
| ab_ck_en_n | input | 1 | A-to-B capture enable, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A latch enable, high means transparent |
| ba_ck | input | 1 | B-to-A capture clock |
| ba_ck_en_n | input | 1 | B-to-A capture enable, active low |

## Verification
The bench goes after the hand-off from transparent to hold. A design that stored nothing while transparent would show stale data once the latch enable fell. It also targets a latch enable that falls with the capture clock already high. A design that looked for levels instead of edges would keep capturing in that case. Blocked edges while the capture enable is high are probed, because a design that ignored the enable would let new data through. A capture clock held high across reset is also probed, because a design whose edge history restarted at zero would see a phantom capture. Random mixes of all eight controls then compare both paths against a bench model, to catch crossed controls between the two directions.

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_ck,
  input  logic         ab_ck_en_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_ck,
  input  logic         ba_ck_en_n
);

  logic [W-1:0] ab_q, ba_q;
  logic         ab_ck_q, ba_ck_q;

  wire ab_take = ab_le | (~ab_ck_en_n & ab_ck & ~ab_ck_q);
  wire ba_take = ba_le | (~ba_ck_en_n & ba_ck & ~ba_ck_q);

  always_ff @(posedge clk) begin
    ab_ck_q <= ab_ck;
    ba_ck_q <= ba_ck;
    if (rst) begin
      ab_q <= '0;
      ba_q <= '0;
    end else begin
      if (ab_take) ab_q <= a_in;
      if (ba_take) ba_q <= b_in;
    end
  end

  assign b_out = ab_le ? a_in : ab_q;
  assign a_out = ba_le ? b_in : ba_q;
  assign b_drv = ~ab_oe_n;
  assign a_drv = ~ba_oe_n;

endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         ab_le,
  input logic         ab_ck,
  input logic         ab_ck_en_n,
  input logic         ba_le,
  input logic         ba_ck,
  input logic         ba_ck_en_n
);

  // R3
  ab_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !ab_ck_en_n && ab_ck && !$past(ab_ck)) |=> (ab_le || b_out == $past(a_in)));

  // R4
  ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !(ab_ck && !$past(ab_ck) && !ab_ck_en_n)) |=> (ab_le || $stable(b_out)));

  // R6
  ab_lefall_chk: assert property (@(posedge clk) disable iff (rst)
    ab_le |=> (ab_le || b_out == $past(a_in)));

  // R8
  ab_reset_chk: assert property (@(posedge clk)
    rst |=> (ab_le || b_out == '0));

  // R7
  ba_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !ba_ck_en_n && ba_ck && !$past(ba_ck)) |=> (ba_le || a_out == $past(b_in)));

  // R7
  ba_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !(ba_ck && !$past(ba_ck) && !ba_ck_en_n)) |=> (ba_le || $stable(a_out)));

  // R7
  ba_lefall_chk: assert property (@(posedge clk) disable iff (rst)
    ba_le |=> (ba_le || a_out == $past(b_in)));

  // R8
  ba_reset_chk: assert property (@(posedge clk)
    rst |=> (ba_le || a_out == '0));

endmodule

bind bus_xcvr bus_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bus_xcvr.sv
module tb_bus_xcvr;
  localparam int W = 18;

  logic clk = 0;
  logic rst = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drv, b_drv;
  logic ab_oe_n = 1, ab_le = 0, ab_ck = 0, ab_ck_en_n = 1;
  logic ba_oe_n = 1, ba_le = 0, ba_ck = 0, ba_ck_en_n = 1;

  int checks = 0;
  int errors = 0;
  int both_on = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic m_abck = 0, m_back = 0;

  always #5 clk = ~clk;

  bus_xcvr #(.W(W)) dut (.*);

  always @(posedge clk) begin
    if (rst) begin
      m_ab = '0;
      m_ba = '0;
    end else begin
      if (ab_le || (!ab_ck_en_n && ab_ck && !m_abck)) m_ab = a_in;
      if (ba_le || (!ba_ck_en_n && ba_ck && !m_back)) m_ba = b_in;
    end
    m_abck = ab_ck;
    m_back = ba_ck;
  end

  function automatic logic [W-1:0] exp_b();
    return ab_le ? a_in : m_ab;
  endfunction

  function automatic logic [W-1:0] exp_a();
    return ba_le ? b_in : m_ba;
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_model();
    check(W'(b_drv), W'(!ab_oe_n), "R1 b_drv");
    check(W'(a_drv), W'(!ba_oe_n), "R1 a_drv");
    check(b_out, exp_b(), ab_le ? "R2 b_out" : "R4 b_out");
    check(a_out, exp_a(), "R7 a_out");
    if (!ab_oe_n && !ba_oe_n) both_on++;
  endtask

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    ab_ck = 1;
    a_in = 18'h3ffff;
    b_in = 18'h15555;
    repeat (3) nxt();
    rst = 0;
    nxt();
    // R8: cleared storage, no phantom capture from ab_ck held high through reset
    ab_ck_en_n = 0;
    check(b_out, '0, "R8 b_out");
    check(a_out, '0, "R8 a_out");
    nxt();
    check(b_out, '0, "R8 no phantom edge");
    // R1
    ab_oe_n = 0; #1;
    check(W'(b_drv), W'(1), "R1 drive on");
    ab_oe_n = 1; #1;
    check(W'(b_drv), W'(0), "R1 drive off");

    // R6: fall of latch enable with clock high keeps last transparent value
    ab_le = 1; a_in = 18'h0abcd; #1;
    check(b_out, 18'h0abcd, "R2 transparent");
    nxt();
    ab_le = 0; a_in = 18'h11111; #1;
    check(b_out, 18'h0abcd, "R6 b_out");
    nxt();
    nxt();
    // R4: clock steady high, nothing captured
    check(b_out, 18'h0abcd, "R4 steady high");

    // R5: disabled capture edge ignored
    ab_ck = 0; ab_ck_en_n = 1;
    nxt();
    ab_ck = 1; a_in = 18'h22222;
    nxt();
    nxt();
    check(b_out, 18'h0abcd, "R5 blocked edge");

    // R3: enabled edge captures
    ab_ck = 0; ab_ck_en_n = 0;
    nxt();
    ab_ck = 1; a_in = 18'h33333; #1;
    check(b_out, 18'h0abcd, "R3 before edge");
    nxt();
    a_in = 18'h04444; #1;
    check(b_out, 18'h33333, "R3 after edge");

    // R7: mirror path
    ba_le = 1; b_in = 18'h2aaaa;
    nxt();
    ba_le = 0; b_in = 18'h01234; #1;
    check(a_out, 18'h2aaaa, "R7 latch fall");
    ba_ck_en_n = 0; ba_ck = 0;
    nxt();
    ba_ck = 1;
    nxt();
    check(a_out, 18'h01234, "R7 capture");

    for (int i = 0; i < 3000; i++) begin
      ab_oe_n    = $urandom_range(0, 1);
      ba_oe_n    = $urandom_range(0, 1);
      ab_le      = ($urandom_range(0, 3) == 0);
      ba_le      = ($urandom_range(0, 3) == 0);
      ab_ck_en_n = ($urandom_range(0, 2) == 0);
      ba_ck_en_n = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 1) == 1) ab_ck = ~ab_ck;
      if ($urandom_range(0, 1) == 1) ba_ck = ~ba_ck;
      a_in = W'($urandom);
      b_in = W'($urandom);
      #1;
      check_model();
      nxt();
    end

    $display("Both directions driving in %0d random cycles", both_on);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule